// File: doc/BRIEF.md
# Mode-Aware Linear Address Qualifier

This block stands between address generation and the translation logic. It takes a 64-bit linear address, together with the state that selects the processor's operating sub-mode, and turns them into a 48-bit address that the page walker can use. It also produces a general-protection fault flag. Three sub-modes exist. The block is outside long mode when the long-mode enable is clear or paging is off. When both are set, the block is in the compatibility sub-mode or the 64-bit sub-mode, and the 64-bit-code indicator picks which.

Only the 64-bit sub-mode checks the address. In that sub-mode, the top seventeen bits must all match, which makes the address canonical. A non-canonical address raises a fault with error code zero, the output address is cleared, and no translation request goes out. In the other two sub-modes, only the low 32 bits are forwarded and the upper forwarded bits are forced to zero. These sub-modes never fault.

The block has one register stage. A request sampled on one clock edge gives its result, valid flag and fault flag on the next edge.

Top module: `lin_addr_qual`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `req_valid` high, and the result describes that request.
- R2: In the 64-bit sub-mode (`lme_on`=1, `paging_on`=1, `code64`=1), if address bits 63 down to 47 are all equal, `out_addr` equals bits 47:0 of the request, `out_fault` is 0 and `out_xlate` is 1.
- R3: In the 64-bit sub-mode, if address bits 63 down to 47 are not all equal, `out_fault` is 1.
- R4: Whenever `out_fault` is 1, `out_addr` is zero and `out_xlate` is 0.
- R5: In the compatibility sub-mode (`lme_on`=1, `paging_on`=1, `code64`=0), `out_addr` is bits 31:0 of the request with bits 47:32 zero, and `out_fault` is 0 whatever the upper request bits hold.
- R6: Outside long mode, `out_addr` is the request's bits 31:0 zero-extended to 48 bits, and `out_fault` is never raised.
- R7: `code64` has no effect unless `lme_on` and `paging_on` are both 1. In that case a non-canonical address passes with its upper bits dropped.
- R8: Driving `rst_n` low clears `out_valid` and `out_fault` at once, without waiting for a clock edge. While `rst_n` is low, requests are ignored.
- R9: After a cycle with `req_valid` low, `out_valid`, `out_fault` and `out_xlate` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Linear address of the request |
| lme_on | input | 1 | Long-mode enable |
| paging_on | input | 1 | Paging enabled |
| code64 | input | 1 | Current code runs in the 64-bit sub-mode (used only in long mode) |
| out_valid | output | 1 | Result present, one cycle after the request |
| out_addr | output | 48 | Qualified address for translation, zero on fault |
| out_fault | output | 1 | General-protection fault, error code zero |
| out_xlate | output | 1 | Translation request forwarded (valid and no fault) |

## Verification
The design has little internal state: the sub-mode decode, the canonical flag and the single output register. Each wrong decision therefore appears on the ports in the cycle right after the request that caused it. A wrong sub-mode decode or sign check shows up as a missing or spurious fault, or as upper address bits that leak through. A valid flag that sticks or is dropped shows up as a result with no matching request, or as a request with no result, one edge later. Asynchronous reset is checked between clock edges so that its immediate effect is seen.

// File: rtl/laq_pkg.sv
package laq_pkg;
  typedef enum logic [1:0] {
    SUB_LEGACY = 2'd0,
    SUB_COMPAT = 2'd1,
    SUB_64     = 2'd2
  } submode_e;
endpackage

// File: rtl/laq_rst_sync.sv
module laq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/laq_mode_dec.sv
module laq_mode_dec
  import laq_pkg::*;
(
  input  logic     lme_on,
  input  logic     paging_on,
  input  logic     code64,
  output submode_e mode
);
  logic long_active;

  always_comb begin
    long_active = lme_on & paging_on;
    if (!long_active)  mode = SUB_LEGACY;
    else if (code64)   mode = SUB_64;
    else               mode = SUB_COMPAT;
  end
endmodule

// File: rtl/laq_canon_chk.sv
module laq_canon_chk #(
  parameter int VA_W = 64,
  parameter int LA_W = 48
) (
  input  logic [VA_W-1:0] addr,
  output logic            canon
);
  localparam int HI_W = VA_W - LA_W + 1;

  logic [HI_W-1:0] hi_bits;

  always_comb begin
    hi_bits = addr[VA_W-1:LA_W-1];
    canon   = (&hi_bits) | ~(|hi_bits);
  end
endmodule

// File: rtl/laq_shape.sv
module laq_shape
  import laq_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int LA_W     = 48,
  parameter int NARROW_W = 32
) (
  input  logic [VA_W-1:0] addr,
  input  submode_e        mode,
  input  logic            canon,
  output logic [LA_W-1:0] addr_out,
  output logic            fault
);
  localparam int PAD_W = LA_W - NARROW_W;

  logic [LA_W-1:0] narrow_addr;
  logic [LA_W-1:0] wide_addr;

  generate
    if (PAD_W > 0) begin : g_pad
      assign narrow_addr = {{PAD_W{1'b0}}, addr[NARROW_W-1:0]};
    end else begin : g_nopad
      assign narrow_addr = addr[LA_W-1:0];
    end
  endgenerate

  assign wide_addr = addr[LA_W-1:0];

  always_comb begin
    fault    = 1'b0;
    addr_out = narrow_addr;
    if (mode == SUB_64) begin
      fault    = ~canon;
      addr_out = canon ? wide_addr : '0;
    end
  end
endmodule

// File: rtl/lin_addr_qual.sv
module lin_addr_qual
  import laq_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int LA_W     = 48,
  parameter int NARROW_W = 32,
  parameter int SYNC_STG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_addr,
  input  logic            lme_on,
  input  logic            paging_on,
  input  logic            code64,
  output logic            out_valid,
  output logic [LA_W-1:0] out_addr,
  output logic            out_fault,
  output logic            out_xlate
);
  localparam int HI_W = LA_W - NARROW_W;

  logic            rst_sync_n;
  submode_e        mode;
  logic            canon;
  logic [LA_W-1:0] shaped_addr;
  logic            shaped_fault;

  logic            valid_d, valid_q;
  logic            fault_d, fault_q;
  logic [LA_W-1:0] addr_d,  addr_q;
  logic            addr_en;

  laq_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  laq_mode_dec u_mode_dec (
    .lme_on    (lme_on),
    .paging_on (paging_on),
    .code64    (code64),
    .mode      (mode)
  );

  laq_canon_chk #(.VA_W(VA_W), .LA_W(LA_W)) u_canon (
    .addr  (req_addr),
    .canon (canon)
  );

  laq_shape #(.VA_W(VA_W), .LA_W(LA_W), .NARROW_W(NARROW_W)) u_shape (
    .addr     (req_addr),
    .mode     (mode),
    .canon    (canon),
    .addr_out (shaped_addr),
    .fault    (shaped_fault)
  );

  // next state
  always_comb begin
    valid_d = req_valid;
    fault_d = req_valid & shaped_fault;
    addr_en = req_valid;
    addr_d  = shaped_addr;
  end

  // control registers, cleared by reset
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
    end
  end

  // datapath register, enable only
  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= addr_d;
  end

  assign out_valid = valid_q;
  assign out_fault = fault_q;
  assign out_addr  = fault_q ? '0 : addr_q;
  assign out_xlate = valid_q & ~fault_q;

  // ---------------- assertions ----------------
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> out_valid);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!out_valid && !out_fault && !out_xlate));

  assert_canon_pass_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && mode == SUB_64 && canon)
      |=> (!out_fault && out_xlate && out_addr == $past(req_addr[LA_W-1:0])));

  assert_noncanon_fault_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && mode == SUB_64 && !canon) |=> (out_fault && !out_xlate));

  assert_fault_zero_addr_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_fault |-> (out_addr == '0 && !out_xlate));

  assert_narrow_no_fault_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && mode != SUB_64) |=> !out_fault);

  assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && mode != SUB_64) |=> (out_addr[LA_W-1:LA_W-HI_W] == '0));

  assert_mode_gate_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(lme_on && paging_on)) |-> (mode == SUB_LEGACY));
endmodule

// File: tb/lin_addr_qual_bench.sv
module lin_addr_qual_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_addr;
  logic        lme_on, paging_on, code64;
  logic        out_valid;
  logic [47:0] out_addr;
  logic        out_fault;
  logic        out_xlate;

  int checks = 0;
  int bad    = 0;
  logic mon_on = 1'b0;
  logic done   = 1'b0;

  typedef struct {
    logic [47:0] addr;
    logic        fault;
    string       tag;
  } exp_t;
  exp_t q[$];

  lin_addr_qual u_lin_addr_qual (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .lme_on(lme_on), .paging_on(paging_on), .code64(code64),
    .out_valid(out_valid), .out_addr(out_addr), .out_fault(out_fault),
    .out_xlate(out_xlate)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // reference model built from the requirements
  function automatic exp_t model(input logic [63:0] a, input logic l,
                                 input logic p, input logic c, input string tag);
    exp_t e;
    e.tag = tag;
    if (l && p && c) begin
      if (a[63:47] == 17'h0 || a[63:47] == 17'h1ffff) begin
        e.fault = 1'b0;
        e.addr  = a[47:0];
      end else begin
        e.fault = 1'b1;
        e.addr  = '0;
      end
    end else begin
      e.fault = 1'b0;
      e.addr  = {16'h0, a[31:0]};
    end
    return e;
  endfunction

  task automatic send(input logic [63:0] a, input logic l, input logic p,
                      input logic c, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; lme_on = l; paging_on = p; code64 = c;
    q.push_back(model(a, l, p, c, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = 64'hffff_ffff_ffff_ffff;
      code64    = 1'b1;
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 unexpected result", 64'(out_valid), 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_addr == e.addr, e.tag, 64'(out_addr), 64'(e.addr));
          chk(out_fault == e.fault, e.tag, 64'(out_fault), 64'(e.fault));
          chk(out_xlate == !e.fault, "R4 xlate", 64'(out_xlate), 64'(!e.fault));
        end
      end else begin
        chk(q.size() == 0, "R1 missing result", 64'(out_valid), 64'd1);
        chk(!out_fault && !out_xlate, "R9 idle outputs",
            64'({out_fault, out_xlate}), 64'd0);
        if (q.size() != 0) void'(q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    checks++; bad++;
    $display("FAIL watchdog expired got=1 exp=0");
    finish_run();
  end

  initial begin
    logic [63:0] lfsr;
    rst_n = 1'b0; req_valid = 1'b1; req_addr = 64'h8000_0000_0000_0000;
    lme_on = 1'b1; paging_on = 1'b1; code64 = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R8: requests ignored during reset
    chk(!out_valid && !out_fault, "R8 reset state", 64'({out_valid, out_fault}), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R2 canonical in 64-bit sub-mode
    send(64'h0000_7fff_ffff_f000, 1, 1, 1, "R2 low canonical");
    send(64'hffff_8000_0000_0000, 1, 1, 1, "R2 high canonical");
    send(64'h0000_0000_0000_0000, 1, 1, 1, "R2 zero");
    // R3 non-canonical
    send(64'h0000_8000_0000_0000, 1, 1, 1, "R3 bit47 only");
    send(64'hfffe_7fff_ffff_ffff, 1, 1, 1, "R3 bit48 clear");
    send(64'h8000_0000_0000_1234, 1, 1, 1, "R3 bit63 only");
    // R5 compatibility sub-mode
    send(64'hdead_beef_1234_5678, 1, 1, 0, "R5 compat garbage upper");
    send(64'h0000_8000_ffff_ffff, 1, 1, 0, "R5 compat noncanon");
    idle(2);
    // R6 outside long mode
    send(64'h8000_0000_cafe_f00d, 0, 1, 0, "R6 lme off");
    send(64'h1234_5678_9abc_def0, 0, 0, 0, "R6 all off");
    // R7 code64 ignored outside long mode
    send(64'h0000_8000_0000_0001, 1, 0, 1, "R7 paging off code64");
    send(64'hff00_0000_0000_0002, 0, 1, 1, "R7 lme off code64");
    idle(1);
    // R1 back-to-back mixed stream
    lfsr = 64'h1d87_2b41_9e3c_5a60;
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      a = lfsr;
      if (i % 3 == 0) a[63:47] = {17{a[5]}};
      send(a, lfsr[1] | lfsr[7], lfsr[2] | lfsr[9], lfsr[3], "R1 stream");
      if (i % 7 == 6) idle(1);
    end
    idle(2);

    // R8 asynchronous reset mid-run
    mon_on = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h0000_8000_0000_0000;
    lme_on = 1; paging_on = 1; code64 = 1;
    @(posedge clk); #1;
    chk(out_valid && out_fault, "R1 pre-reset result", 64'({out_valid, out_fault}), 64'd3);
    rst_n = 1'b0;
    #0.5;
    chk(!out_valid && !out_fault, "R8 async clear", 64'({out_valid, out_fault}), 64'd0);
    repeat (2) @(posedge clk);
    #1;
    chk(!out_valid, "R8 held in reset", 64'(out_valid), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    send(64'hffff_ffff_ffff_fff8, 1, 1, 1, "R2 after reset");
    idle(3);
    finish_run();
  end
endmodule